// File: doc/BRIEF.md
# Timer capture/compare channel

This block is one 16-bit channel that sits next to a free-running 16-bit up counter. The counter itself lives elsewhere. The channel receives the count value and a wrap indication from it. One mode input chooses what the channel does. With the mode low it acts as a compare unit: the host loads a value, and the channel raises a one-cycle interrupt each time the count arrives at that value. With the mode high it acts as a capture unit: a chosen edge on an external trigger pin copies the current count into the channel register and raises the same interrupt.

The trigger pin is asynchronous. It passes through a synchroniser clocked by the timer clock before any edge is detected. A two-bit field selects which edge counts. One of its four codes is reserved. While that code is selected the channel ignores every edge and raises a flag.

The host can write the register at any time. A capture in the same cycle takes priority over the write. A read captures the register into a holding output. If the count was stopped at the instant of a capture, the captured value could not be trusted. The channel then leaves the register alone and pulses an error output.

Top module: `capcmp_channel`

## Requirements
- R1: While reset is asserted, and after it is released, the register, `rd_data`, `irq` and `cap_err` are all zero.
- R2: With `cap_mode`=0 and a nonzero register value V, `irq` is high for exactly one cycle. That cycle follows the first cycle in which `cnt_val` equals V. If the count then stays at V, no further pulse is raised until the count leaves V and returns.
- R3: With `cap_mode`=0 and a register value of 0000H, `cnt_val`=0000H never causes an interrupt. Instead `irq` pulses once, in the cycle after `cnt_val` reads 0001H, provided `cnt_ovf` was high on the 0000H that preceded it. A value of 0001H reached without a preceding overflow raises nothing.
- R4: The `edge_sel` field decodes as follows: 2'b00 selects falling edges of the trigger, 2'b01 selects rising edges, and 2'b11 selects both. 2'b10 is reserved: it selects no edge, and `illegal_cfg` is high while it is applied.
- R5: With `cap_mode`=1, suppose `trig_pin` takes a new level before clock edge k and the edge is a valid one. Then at edge k+2 the register loads the `cnt_val` presented in the cycle before that edge, and `irq` is high for the following cycle.
- R6: A `wr_en` cycle loads `wr_data` into the register at the next edge, in either mode. If a capture happens at the same edge, the captured count is stored and the write is dropped.
- R7: If a capture edge and `cnt_stop` fall in the same cycle, the register keeps its previous value, any coincident write is dropped, `cap_err` pulses high for one cycle, and `irq` still pulses.
- R8: When `rd_en` is high, `rd_data` takes the register value held before that edge, even if a capture or write lands at the same edge. `rd_data` then holds until the next read.
- R9: In compare mode, trigger edges neither change the register nor raise `irq`. In capture mode, count matches raise no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_val | input | 16 | Current value of the external up counter |
| cnt_ovf | input | 1 | High in the cycle the counter shows 0000H after wrapping from FFFFH |
| cnt_stop | input | 1 | Count-stop indication from the counter |
| cap_mode | input | 1 | 1 = capture, 0 = compare |
| edge_sel | input | 2 | Trigger edge code (see R4) |
| trig_pin | input | 1 | Asynchronous external trigger |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 16 | Host write value |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | 16 | Register value sampled by the last read |
| irq | output | 1 | One-cycle interrupt pulse |
| cap_err | output | 1 | One-cycle pulse when a capture collided with count-stop |
| illegal_cfg | output | 1 | High while the reserved edge code is selected |

## Verification
The bench targets five corner cases, each with a distinct failure signature.

- **Zero compare value.** The bench runs the counter through FFFFH into 0001H. It also jumps straight to 0001H without an overflow. A design that matched on 0000H would fire one step early, and one that ignored the overflow would fire on the jump.
- **Count parked on the compare value.** This checks that the interrupt is an arrival pulse. A level-sensitive design would raise a stream of interrupts.
- **Edge codes.** Every code is exercised with both pin directions. A wrong decode would capture on the wrong edge or capture under the reserved code.
- **Synchroniser latency.** This is checked by which count lands in the register. A wrong flop count would store a neighbouring value.
- **Capture collisions.** Captures are made to collide with a write, with count-stop and with a read. These catch a wrong priority, a corrupted register on a stopped count, and a read that returns the new value instead of the old.

// File: rtl/capcmp_pkg.sv
// Shared types for the capture/compare channel.
// Assumes: edge codes are two bits wide and one code is reserved.
package capcmp_pkg;

    // Trigger edge selection; the numeric values are the port encoding.
    typedef enum logic [1:0] {
        EDGE_FALL = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_RSVD = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

endpackage

// File: rtl/capcmp_edge_detect.sv
// Synchronises the asynchronous trigger pin into the timer clock domain and
// reports a one-cycle valid edge according to the selected edge code.
// Assumes: SYNC_STAGES >= 2; the pin is treated as fully asynchronous.
module capcmp_edge_detect
    import capcmp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin,
    input  edge_sel_e edge_sel,
    output logic      valid_edge,
    output logic      illegal
);

    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] sync_q;
    logic         last_q;
    logic         rise;
    logic         fall;

    // Shift the pin through the synchroniser and keep the previous settled level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[MSB-1:0], pin};
            last_q <= sync_q[MSB];
        end
    end

    assign rise = sync_q[MSB] & ~last_q;
    assign fall = ~sync_q[MSB] & last_q;

    // Decode the edge code into a qualified edge strobe.
    always_comb begin
        unique case (edge_sel)
            EDGE_FALL: valid_edge = fall;
            EDGE_RISE: valid_edge = rise;
            EDGE_BOTH: valid_edge = rise | fall;
            default:   valid_edge = 1'b0;
        endcase
    end

    assign illegal = (edge_sel == EDGE_RSVD);

    // R4: the reserved code never yields an edge, whatever the pin does.
    a_r4_reserved_no_edge: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !valid_edge)
        else $error("reserved edge code produced an edge");

endmodule

// File: rtl/capcmp_match.sv
// Compare engine: raises a one-cycle event when the counter arrives at the
// compare value. A compare value of zero is handled as the step from zero to
// one that follows a counter wrap.
// Assumes: cnt_ovf is high only in a cycle where cnt_val reads zero.
module capcmp_match #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic [W-1:0] cnt_val,
    input  logic         cnt_ovf,
    input  logic [W-1:0] cmp_val,
    output logic         match_evt
);

    localparam logic [W-1:0] STEP_ONE = W'(1);

    logic armed_q;
    logic hit_q;
    logic hit;

    assign hit = enable & ((cmp_val != '0) ? (cnt_val == cmp_val)
                                           : (armed_q && cnt_val == STEP_ONE));
    assign match_evt = hit & ~hit_q;

    // Remember a wrap until the counter leaves zero; remember the last hit level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            hit_q   <= 1'b0;
        end else begin
            if (cnt_ovf)
                armed_q <= 1'b1;
            else if (cnt_val != '0)
                armed_q <= 1'b0;
            hit_q <= hit;
        end
    end

    // R3: a zero compare value never matches on a zero count.
    a_r3_no_fire_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_val == '0 && cnt_val == '0) |-> !match_evt)
        else $error("zero compare fired on a zero count");

    // R2: match events are single-cycle pulses.
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        match_evt |=> !match_evt)
        else $error("match event lasted more than one cycle");

endmodule

// File: rtl/capcmp_channel.sv
// 16-bit capture/compare channel for a free-running up counter.
// Holds one register that is either compared against the count or loaded
// from it on a trigger edge, arbitrates host writes against captures, and
// returns reads of the pre-edge register value.
// Assumes: counter and prescaler are external; cnt_ovf accompanies the
// zero count that follows FFFFH.
module capcmp_channel #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_ovf,
    input  logic             cnt_stop,
    input  logic             cap_mode,
    input  logic [1:0]       edge_sel,
    input  logic             trig_pin,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             rd_en,
    output logic [CNT_W-1:0] rd_data,
    output logic             irq,
    output logic             cap_err,
    output logic             illegal_cfg
);

    logic [CNT_W-1:0] cr_q;
    logic [CNT_W-1:0] rd_q;
    logic             irq_q;
    logic             err_q;
    logic             trig_edge;
    logic             match_evt;
    logic             cap_evt;
    logic             cap_ok;
    logic             cap_bad;

    capcmp_edge_detect #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin       (trig_pin),
        .edge_sel  (capcmp_pkg::edge_sel_e'(edge_sel)),
        .valid_edge(trig_edge),
        .illegal   (illegal_cfg)
    );

    capcmp_match #(
        .W(CNT_W)
    ) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (~cap_mode),
        .cnt_val  (cnt_val),
        .cnt_ovf  (cnt_ovf),
        .cmp_val  (cr_q),
        .match_evt(match_evt)
    );

    assign cap_evt = cap_mode & trig_edge;
    assign cap_ok  = cap_evt & ~cnt_stop;
    assign cap_bad = cap_evt & cnt_stop;

    // Register update: capture beats host write; a stopped-count capture leaves it alone.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cr_q <= '0;
        else if (cap_ok)
            cr_q <= cnt_val;
        else if (!cap_evt && wr_en)
            cr_q <= wr_data;
    end

    // Read port: sample the value held before this edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_q <= '0;
        else if (rd_en)
            rd_q <= cr_q;
    end

    // Interrupt and collision error pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            irq_q <= cap_evt | match_evt;
            err_q <= cap_bad;
        end
    end

    assign rd_data = rd_q;
    assign irq     = irq_q;
    assign cap_err = err_q;

    // R5: a clean capture stores the count seen in the capture cycle.
    a_r5_capture_loads: assert property (@(posedge clk) disable iff (!rst_n)
        cap_ok |=> cr_q == $past(cnt_val))
        else $error("capture stored the wrong count");

    // R7: after a collision with count-stop the register is unchanged.
    a_r7_conflict_holds: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> cr_q == $past(cr_q))
        else $error("register changed on a stopped-count capture");

    // R6: a write without a capture lands on the next edge.
    a_r6_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !cap_evt) |=> cr_q == $past(wr_data))
        else $error("host write lost");

    // R8: a read returns the pre-edge register value.
    a_r8_read_old: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_q == $past(cr_q))
        else $error("read returned post-edge value");

    // R9: in capture mode only captures raise the interrupt.
    a_r9_capture_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_mode && !cap_evt) |=> !irq_q)
        else $error("interrupt without capture in capture mode");

endmodule

// File: tb/capcmp_channel_tb.sv
// Bench for capcmp_channel: a behavioural reference model runs alongside the
// design and every output is compared once per clock.
module capcmp_channel_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cnt_val;
    logic        cnt_ovf, cnt_stop, cap_mode, trig_pin, wr_en, rd_en;
    logic [1:0]  edge_sel;
    logic [15:0] wr_data;
    logic [15:0] rd_data;
    logic        irq, cap_err, illegal_cfg;

    int    n_tests = 0;
    int    n_fail  = 0;
    int    irq_seen = 0;
    bit    run = 0;
    bit    done = 0;
    string tag = "R1";

    always #5 clk = ~clk;

    capcmp_channel u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_ovf(cnt_ovf),
        .cnt_stop(cnt_stop), .cap_mode(cap_mode), .edge_sel(edge_sel),
        .trig_pin(trig_pin), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .irq(irq), .cap_err(cap_err), .illegal_cfg(illegal_cfg)
    );

    // ---------------- reference model ----------------
    int m_reg = 0, m_rd = 0;
    bit m_irq = 0, m_err = 0, m_armed = 0, m_hitq = 0;
    bit p0 = 0, p1 = 0, p2 = 0;   // pin history, newest first

    always @(posedge clk) begin
        bit edge_ok, hit;
        int old_reg;
        if (!rst_n) begin
            m_reg = 0; m_rd = 0; m_irq = 0; m_err = 0;
            m_armed = 0; m_hitq = 0; p0 = 0; p1 = 0; p2 = 0;
        end else begin
            case (edge_sel)
                2'b00:   edge_ok = !p1 && p2;
                2'b01:   edge_ok = p1 && !p2;
                2'b11:   edge_ok = p1 != p2;
                default: edge_ok = 0;
            endcase
            p2 = p1; p1 = p0; p0 = trig_pin;
            old_reg = m_reg;
            if (old_reg != 0) hit = !cap_mode && (int'(cnt_val) == old_reg);
            else              hit = !cap_mode && m_armed && (cnt_val == 16'd1);
            if (rd_en) m_rd = old_reg;
            m_err = cap_mode && edge_ok && cnt_stop;
            if (cap_mode && edge_ok) begin
                if (!cnt_stop) m_reg = cnt_val;
            end else if (wr_en) m_reg = wr_data;
            m_irq = (cap_mode && edge_ok) || (hit && !m_hitq);
            m_hitq = hit;
            if (cnt_ovf) m_armed = 1;
            else if (cnt_val != 0) m_armed = 0;
        end
    end

    task automatic check(input string what, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // One clock: compare all outputs, then step the bench counter.
    task automatic cyc();
        @(posedge clk);
        #2;
        check("irq", int'(irq), int'(m_irq));
        check("cap_err", int'(cap_err), int'(m_err));
        check("rd_data", int'(rd_data), m_rd);
        check("illegal_cfg", int'(illegal_cfg), int'(edge_sel == 2'b10));
        if (irq) irq_seen++;
        if (run) begin
            cnt_val = cnt_val + 16'd1;
            cnt_ovf = (cnt_val == 16'd0);
        end else cnt_ovf = 1'b0;
    endtask

    task automatic host_write(input logic [15:0] v);
        wr_en = 1; wr_data = v; cyc(); wr_en = 0;
    endtask

    task automatic toggle_pin(input int n);
        for (int i = 0; i < n; i++) begin
            trig_pin = ~trig_pin;
            repeat (4) cyc();
        end
    endtask

    initial begin
        rst_n = 0; cnt_val = 0; cnt_ovf = 0; cnt_stop = 0; cap_mode = 0;
        edge_sel = 2'b01; trig_pin = 0; wr_en = 0; wr_data = 0; rd_en = 0;
        repeat (3) cyc();
        check("R1 rd_data in reset", int'(rd_data), 0);
        rst_n = 1;
        cyc();
        check("R1 irq after reset", int'(irq), 0);

        // R6 / R8: write then read back
        tag = "R6";
        host_write(16'h0010);
        tag = "R8";
        rd_en = 1; cyc(); rd_en = 0; cyc();
        check("R8 read back", int'(rd_data), 16'h0010);

        // R2: count past 0010H, then park on it
        tag = "R2"; irq_seen = 0;
        run = 1; cnt_val = 0;
        repeat (24) cyc();
        run = 0; cnt_val = 16'h0010;
        repeat (6) cyc();
        check("R2 pulses", irq_seen, 2);

        // R3: zero compare across a wrap, and 0001H without a wrap
        tag = "R3";
        host_write(16'h0000);
        irq_seen = 0; run = 1; cnt_val = 16'hFFF8;
        repeat (16) cyc();
        check("R3 wrap pulses", irq_seen, 1);
        irq_seen = 0; run = 0; cnt_val = 16'h0000; cyc(); cnt_val = 16'h0001;
        repeat (4) cyc();
        check("R3 no-wrap pulses", irq_seen, 0);

        // R9: edges ignored in compare mode
        tag = "R9"; irq_seen = 0; run = 1; cnt_val = 16'h0100;
        toggle_pin(6);
        check("R9 compare-mode edges", irq_seen, 0);
        host_write(16'h0105);
        cnt_val = 16'h0100; cap_mode = 1; irq_seen = 0;
        repeat (10) cyc();
        check("R9 no match irq in capture", irq_seen, 0);

        // R5 / R4: capture on each edge code
        tag = "R5"; edge_sel = 2'b01; irq_seen = 0;
        toggle_pin(4);
        check("R5 rising captures", irq_seen, 2);
        tag = "R4";
        edge_sel = 2'b00; irq_seen = 0; toggle_pin(4);
        check("R4 falling captures", irq_seen, 2);
        edge_sel = 2'b11; irq_seen = 0; toggle_pin(4);
        check("R4 both captures", irq_seen, 4);
        edge_sel = 2'b10; irq_seen = 0; toggle_pin(4);
        check("R4 reserved captures", irq_seen, 0);
        check("R4 illegal flag", int'(illegal_cfg), 1);
        rd_en = 1; cyc(); rd_en = 0; cyc();

        // R7: capture meets count-stop and a write
        tag = "R7"; edge_sel = 2'b01; trig_pin = 0; repeat (4) cyc();
        trig_pin = 1; cyc(); cyc();
        cnt_stop = 1; run = 0; wr_en = 1; wr_data = 16'hBEEF;
        cyc();
        check("R7 cap_err", int'(cap_err), 1);
        cnt_stop = 0; wr_en = 0; run = 1;
        rd_en = 1; cyc(); rd_en = 0; cyc();

        // R6: capture beats write; R8: read in the capture cycle gets the old value
        tag = "R6"; trig_pin = 0; repeat (4) cyc();
        trig_pin = 1; cyc(); cyc();
        wr_en = 1; wr_data = 16'h1234; rd_en = 1;
        cyc();
        tag = "R8";
        wr_en = 0; rd_en = 1; cyc(); rd_en = 0;
        repeat (4) cyc();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule